// File: doc/BRIEF.md
# Shared-Memory Atomic Operation Unit

This block sits in front of a small word-addressed shared memory and serves several requesters. Each requester presents an operation with an address and write data. A round-robin arbiter picks one operation per cycle. The chosen operation reads and, if it writes, updates its word in that same cycle. No other requester can act on the memory between the read and the write, so every read-modify-write is indivisible.

The block offers plain read and write, test-and-set, atomic exchange, fetch-and-increment, and a load-linked/store-conditional pair. Each requester owns one link reservation, which holds a valid bit and an address. Load-linked sets the reservation. Any write to the reserved word breaks it. Store-conditional succeeds only while the reservation holds. Software can build spin locks, counters and barriers from these primitives. A lock word holds 0 when free and 1 when held.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset, every memory word is 0, no reservation is held, rsp_valid is low, and the first grant goes to the lowest-numbered valid requester.
- R2: At most one req_ready bit is high in any cycle, and only for a requester whose req_valid is high. The search for the next grant starts at the requester after the one granted last and wraps around.
- R3: A grant in one cycle raises rsp_valid in the next cycle, with rsp_id set to the granted index. When there is no grant, rsp_valid is low in the next cycle. Requester i drives op bits [3i+2:3i], address bits [AW*i+AW-1:AW*i] and data bits [DW*i+DW-1:DW*i].
- R4: Opcodes are 0 read, 1 write, 2 test-and-set, 3 exchange, 4 fetch-and-increment, 5 load-linked and 6 store-conditional. Every opcode except store-conditional returns the word's value from before the operation. Test-and-set leaves the word at 1.
- R5: Exchange stores the requester's write data and returns the previous value.
- R6: Fetch-and-increment stores the old value plus one, modulo 2^DW, so 0xFFFF becomes 0.
- R7: Load-linked returns the word and records a reservation on that address for the issuer. A plain read leaves every reservation unchanged.
- R8: Store-conditional writes its data and returns 1 only while the issuer holds a reservation on that address. Otherwise it returns 0 and writes nothing. In both cases it clears the issuer's reservation.
- R9: Every memory write clears all reservations on the written address, whichever requester issued it. The write may come from a plain write, test-and-set, exchange, fetch-and-increment or a successful store-conditional. Reservations on other addresses stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request valid, one bit per requester |
| req_op | input | 3*NREQ | Opcode per requester |
| req_addr | input | AW*NREQ | Word address per requester |
| req_wdata | input | DW*NREQ | Write data per requester |
| req_ready | output | NREQ | Grant; the request is taken in this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | clog2(NREQ) | Index of the requester being answered |
| rsp_data | output | DW | Old value, or the success flag for store-conditional |

## Verification
The assertions assume that a requester never sees a response it did not ask for. They also assume that opcode 7 never appears, because its behaviour is left out of the requirements. Random stimulus uses only opcodes 0 to 6. It confines addresses to four words, so reservations, writes and store-conditionals often collide on the same word. Directed runs cover lock acquisition, increment wrap-around, reservations broken by another requester and by the reserving requester's own atomic operation, and store-conditional retried after it has already succeeded.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NREQ = 4,
  parameter int AW   = 4,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREQ-1:0]      req_valid,
  input  logic [3*NREQ-1:0]    req_op,
  input  logic [AW*NREQ-1:0]   req_addr,
  input  logic [DW*NREQ-1:0]   req_wdata,
  output logic [NREQ-1:0]      req_ready,
  output logic                 rsp_valid,
  output logic [$clog2(NREQ)-1:0] rsp_id,
  output logic [DW-1:0]        rsp_data
);
  localparam int IW    = $clog2(NREQ);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_RD = 3'd0, OP_WR = 3'd1, OP_TAS = 3'd2, OP_SWP = 3'd3,
                         OP_INC = 3'd4, OP_LL = 3'd5, OP_SC = 3'd6;

  logic [DW-1:0]   mem   [DEPTH];
  logic [NREQ-1:0] res_v;
  logic [AW-1:0]   res_a [NREQ];
  logic [IW-1:0]   last;

  logic [NREQ-1:0] gnt;
  logic [IW-1:0]   gid;
  logic            any;

  always_comb begin
    gnt = '0;
    gid = '0;
    any = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(last) + k) % NREQ;
      if (!any && req_valid[idx]) begin
        any = 1'b1;
        gid = IW'(idx);
      end
    end
    if (any) gnt[gid] = 1'b1;
  end

  assign req_ready = gnt;

  logic [2:0]    op;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd, old, nv, result;
  logic          sc_ok, do_wr;

  assign op    = req_op[gid*3 +: 3];
  assign addr  = req_addr[gid*AW +: AW];
  assign wd    = req_wdata[gid*DW +: DW];
  assign old   = mem[addr];
  assign sc_ok = res_v[gid] && (res_a[gid] == addr);

  always_comb begin
    do_wr = 1'b0;
    nv    = wd;
    case (op)
      OP_WR:  do_wr = 1'b1;
      OP_TAS: begin do_wr = 1'b1; nv = DW'(1); end
      OP_SWP: do_wr = 1'b1;
      OP_INC: begin do_wr = 1'b1; nv = old + DW'(1); end
      OP_SC:  do_wr = sc_ok;
      default: do_wr = 1'b0;
    endcase
    do_wr = do_wr && any;
  end

  assign result = (op == OP_SC) ? DW'(sc_ok) : old;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int j = 0; j < NREQ; j++) res_a[j] <= '0;
      res_v     <= '0;
      last      <= IW'(NREQ - 1);
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= any;
      if (any) begin
        rsp_id   <= gid;
        rsp_data <= result;
        last     <= gid;
      end
      if (do_wr) mem[addr] <= nv;
      for (int j = 0; j < NREQ; j++)
        if (do_wr && res_a[j] == addr) res_v[j] <= 1'b0;
      if (any && op == OP_LL) begin
        res_v[gid] <= 1'b1;
        res_a[gid] <= addr;
      end
      if (any && op == OP_SC) res_v[gid] <= 1'b0;
    end
  end

  a_r2_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  a_r2_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);
  a_r3_rsp_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> rsp_valid);
  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready) |=> !rsp_valid);
  a_r8_failed_sc_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (any && op == OP_SC && !sc_ok) |=> mem[$past(addr)] == $past(old));
  a_r8_sc_drops_own: assert property (@(posedge clk) disable iff (!rst_n)
    (any && op == OP_SC) |=> !res_v[$past(gid)]);

  for (genvar j = 0; j < NREQ; j++) begin : g_chk
    a_r9_write_breaks_link: assert property (@(posedge clk) disable iff (!rst_n)
      (do_wr && res_a[j] == addr) |=> !res_v[j]);
  end
endmodule

// File: tb/sim_atomic_mem_unit.sv
module sim_atomic_mem_unit;
  localparam int NREQ = 4, AW = 4, DW = 16;
  logic clk = 0, rst_n = 0;
  logic [NREQ-1:0] req_valid = '0;
  logic [3*NREQ-1:0] req_op = '0;
  logic [AW*NREQ-1:0] req_addr = '0;
  logic [DW*NREQ-1:0] req_wdata = '0;
  logic [NREQ-1:0] req_ready;
  logic rsp_valid;
  logic [1:0] rsp_id;
  logic [DW-1:0] rsp_data;

  atomic_mem_unit #(.NREQ(NREQ), .AW(AW), .DW(DW)) u0 (.*);

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [DW-1:0] m_mem [16];
  logic [NREQ-1:0] m_rv;
  logic [AW-1:0] m_ra [NREQ];
  int m_last;
  logic pend; logic [1:0] p_id; logic [DW-1:0] p_data;
  logic [DW-1:0] obs;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic step(logic [3:0] v, logic [11:0] ops, logic [15:0] ads,
                      logic [63:0] wds, string tag);
    logic [3:0] eg; int g; logic [2:0] op; logic [3:0] a; logic [15:0] wd, old;
    logic ok;
    @(negedge clk);
    if (pend) begin
      chk({tag, " R3 valid"}, rsp_valid, 1);
      chk({tag, " R3 id"}, rsp_id, p_id);
      chk({tag, " R4 data"}, rsp_data, p_data);
      obs = rsp_data;
    end else chk({tag, " R3 idle"}, rsp_valid, 0);
    req_valid = v; req_op = ops; req_addr = ads; req_wdata = wds;
    #1;
    g = -1; eg = '0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx = (m_last + k) % NREQ;
      if (g < 0 && v[idx]) g = idx;
    end
    if (g >= 0) eg[g] = 1'b1;
    chk({tag, " R2 grant"}, req_ready, eg);
    pend = (g >= 0);
    if (g >= 0) begin
      op = ops[g*3 +: 3]; a = ads[g*4 +: 4]; wd = wds[g*16 +: 16];
      old = m_mem[a]; ok = m_rv[g] && m_ra[g] == a;
      p_id = 2'(g); p_data = (op == 3'd6) ? 16'(ok) : old;
      m_last = g;
      if (op == 3'd1 || op == 3'd2 || op == 3'd3 || op == 3'd4 || (op == 3'd6 && ok)) begin
        m_mem[a] = (op == 3'd2) ? 16'd1 : (op == 3'd4) ? old + 16'd1 : wd;
        for (int j = 0; j < NREQ; j++) if (m_ra[j] == a) m_rv[j] = 1'b0;
      end
      if (op == 3'd5) begin m_rv[g] = 1'b1; m_ra[g] = a; end
      if (op == 3'd6) m_rv[g] = 1'b0;
    end
  endtask

  task automatic run1(int i, logic [2:0] op, logic [3:0] a, logic [15:0] wd,
                      string tag, logic [15:0] exp);
    logic [11:0] ops = '0; logic [15:0] ads = '0; logic [63:0] wds = '0;
    ops[i*3 +: 3] = op; ads[i*4 +: 4] = a; wds[i*16 +: 16] = wd;
    step(4'(1 << i), ops, ads, wds, tag);
    step(4'b0, '0, '0, '0, tag);
    chk({tag, " literal"}, obs, exp);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    for (int j = 0; j < NREQ; j++) m_ra[j] = '0;
    m_rv = '0; m_last = NREQ - 1; pend = 0; obs = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    step(4'b0, '0, '0, '0, "R1 reset");
    chk("R1 no ready", req_ready, 4'b0);
    step(4'b1111, '0, '0, '0, "R1 first");
    chk("R1 first grant", req_ready, 4'b0001);
    for (int r = 0; r < 4; r++) step(4'b1111, '0, '0, '0, "R2 rotate");
    step(4'b0, '0, '0, '0, "R2 drain");
    run1(1, 3'd2, 4'd5, 16'h0, "R4 tas free", 16'h0);
    run1(1, 3'd2, 4'd5, 16'h0, "R4 tas held", 16'h1);
    run1(2, 3'd3, 4'd5, 16'h00AB, "R5 swap", 16'h1);
    run1(0, 3'd0, 4'd5, 16'h0, "R5 swap read", 16'h00AB);
    run1(0, 3'd1, 4'd6, 16'hFFFF, "R6 preset", 16'h0);
    run1(0, 3'd4, 4'd6, 16'h0, "R6 finc", 16'hFFFF);
    run1(0, 3'd0, 4'd6, 16'h0, "R6 wrap", 16'h0);
    run1(3, 3'd5, 4'd7, 16'h0, "R7 ll", 16'h0);
    run1(0, 3'd0, 4'd7, 16'h0, "R7 read", 16'h0);
    run1(3, 3'd6, 4'd7, 16'h0055, "R8 sc ok", 16'h1);
    run1(0, 3'd0, 4'd7, 16'h0, "R8 sc stored", 16'h0055);
    run1(3, 3'd6, 4'd7, 16'h0066, "R8 sc again", 16'h0);
    run1(2, 3'd5, 4'd8, 16'h0, "R9 ll a", 16'h0);
    run1(1, 3'd5, 4'd9, 16'h0, "R9 ll b", 16'h0);
    run1(0, 3'd1, 4'd8, 16'h1234, "R9 intrude", 16'h0);
    run1(2, 3'd6, 4'd8, 16'h0777, "R9 sc broken", 16'h0);
    run1(0, 3'd0, 4'd8, 16'h0, "R8 no write", 16'h1234);
    run1(1, 3'd6, 4'd9, 16'h0099, "R9 other kept", 16'h1);
    run1(2, 3'd5, 4'd10, 16'h0, "R9 ll self", 16'h0);
    run1(2, 3'd4, 4'd10, 16'h0, "R9 self finc", 16'h0);
    run1(2, 3'd6, 4'd10, 16'h0, "R9 self broken", 16'h0);
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] ops; logic [15:0] ads; logic [63:0] wds;
      for (int i = 0; i < NREQ; i++) begin
        ops[i*3 +: 3] = 3'($urandom_range(0, 6));
        ads[i*4 +: 4] = 4'($urandom_range(0, 3));
        wds[i*16 +: 16] = 16'($urandom);
      end
      step(4'($urandom), ops, ads, wds, "R4 random");
    end
    step(4'b0, '0, '0, '0, "R3 final");
    step(4'b0, '0, '0, '0, "R3 final");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule